// File: doc/BRIEF.md
# Software Write-Protect Command Sequencer

This block sits in front of the write engine of a byte-wide non-volatile array and decides, for every host write strobe, whether that write may reach the array. It keeps a protected bit. Software changes that bit only through fixed address/data command sequences. A three-write sequence arms protection. A six-write sequence arms unprotection. The new state is committed when the write engine signals the end of its write cycle.

The three-write sequence also opens a one-shot data window, so a protected array can still take one page write. The same window follows the six-write sequence. Bytes consumed as command steps never reach the array. Inside an open window only bytes on the page of the first data byte pass. While the array is protected, any write outside a window is refused.

The decision for a strobe is presented as a registered one-cycle qualifier in the cycle after the strobe.

Top module: `wp_seq`

## Requirements
- R1: After a synchronous active-high reset, `prot` is 0 and `wr_allow` is 0.
- R2: With `prot` at 0 and no sequence in progress, a write that is not a command step gives `wr_allow` = 1 in the cycle after the strobe.
- R3: A write accepted as a command step gives `wr_allow` = 0 in the cycle after the strobe, whatever `prot` is.
- R4: The arm-protect sequence is data 0xAA to address 0x5555, then 0x55 to 0x2AAA, then 0xA0 to 0x5555. Only address bits 14..0 are compared, so bits 16..15 are ignored. A `cycle_done` pulse after this sequence makes `prot` 1 in the next cycle.
- R5: The arm-unprotect sequence is 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555. A `cycle_done` pulse after it makes `prot` 0 in the next cycle.
- R6: `prot` changes only in the cycle after `cycle_done` is sampled while a completed sequence is armed. Any other `cycle_done` pulse has no effect.
- R7: With `prot` at 1 and no window open, a write that is not a command step gives `wr_allow` = 0.
- R8: Once a sequence has completed, the first following write is allowed and fixes the page (address bits 16..7). Later writes in the window are allowed only on that page, and writes on any other page give 0.
- R9: A write that does not match the expected next step returns the sequencer to idle. The exception is 0xAA@0x5555, which restarts the sequence at its first step and is itself a command step.
- R10: The committed state takes effect even when no data byte follows the sequence.
- R11: `wr_allow` is 1 only in the cycle right after a sampled strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Host write strobe, one cycle per write |
| wr_addr | input | 17 | Write address |
| wr_data | input | 8 | Write data |
| cycle_done | input | 1 | End-of-write-cycle pulse from the write engine |
| wr_allow | output | 1 | Registered pass qualifier for the previous strobe |
| prot | output | 1 | Protected state bit |

## Verification
The sequencer is driven with:
- plain writes in both protect states, which separates pass-through from blocking;
- complete arm-protect and arm-unprotect sequences, with and without data bytes behind them, which shows the commit does not depend on data;
- command addresses with the upper bits set, which shows those bits are ignored;
- broken sequences and a repeated 0xAA@0x5555 inside a sequence, which separates a plain reset to idle from a restart;
- page writes that wander off their page, which shows the window is locked to the first data byte's page.

A behavioural model in the bench tracks sequence progress as an index into the command list and is compared with both outputs on every cycle.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int CMD_W = 15;
  localparam int NCMD  = 5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_S1, ST_S2, ST_S3, ST_S4, ST_S5, ST_ARM_ON, ST_ARM_OFF
  } wp_state_t;

  // command code indices
  localparam int K_AA = 0;  // 0xAA @ 0x5555
  localparam int K_55 = 1;  // 0x55 @ 0x2AAA
  localparam int K_A0 = 2;  // 0xA0 @ 0x5555
  localparam int K_80 = 3;  // 0x80 @ 0x5555
  localparam int K_20 = 4;  // 0x20 @ 0x5555

  localparam logic [CMD_W-1:0] CMD_ADDR [NCMD] =
    '{15'h5555, 15'h2AAA, 15'h5555, 15'h5555, 15'h5555};
  localparam logic [7:0] CMD_DATA [NCMD] =
    '{8'hAA, 8'h55, 8'hA0, 8'h80, 8'h20};
endpackage

// File: rtl/wp_cmd_decode.sv
module wp_cmd_decode
  import wp_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic [NCMD-1:0]   hit
);
  for (genvar i = 0; i < NCMD; i++) begin : g_cmd
    assign hit[i] = (addr[CMD_W-1:0] == CMD_ADDR[i]) && (data == CMD_DATA[i]);
  end
endmodule

// File: rtl/wp_page_lock.sv
module wp_page_lock #(
  parameter int PAGE_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              load,
  input  logic [PAGE_W-1:0] page_in,
  output logic              valid,
  output logic              mismatch
);
  logic [PAGE_W-1:0] page_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      valid  <= 1'b0;
      page_q <= '0;
    end else if (load && !valid) begin
      valid  <= 1'b1;
      page_q <= page_in;
    end
  end

  assign mismatch = valid && (page_in != page_q);
endmodule

// File: rtl/wp_seq.sv
module wp_seq
  import wp_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 8,
  parameter int PAGE_OFS = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cycle_done,
  output logic              wr_allow,
  output logic              prot
);
  localparam int PAGE_W = ADDR_W - PAGE_OFS;

  wp_state_t       state, state_nx;
  logic [NCMD-1:0] hit;
  logic            armed, commit, pg_valid, pg_mismatch, allow_nx;

  wp_cmd_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .addr (wr_addr),
    .data (wr_data),
    .hit  (hit)
  );

  assign armed  = (state == ST_ARM_ON) || (state == ST_ARM_OFF);
  assign commit = cycle_done && armed;

  wp_page_lock #(.PAGE_W(PAGE_W)) u_page (
    .clk      (clk),
    .rst      (rst),
    .clear    (!armed || commit),
    .load     (wr_stb && armed),
    .page_in  (wr_addr[ADDR_W-1:PAGE_OFS]),
    .valid    (pg_valid),
    .mismatch (pg_mismatch)
  );

  always_comb begin
    state_nx = state;
    if (wr_stb && !armed) begin
      state_nx = hit[K_AA] ? ST_S1 : ST_IDLE;
      unique case (state)
        ST_S1: if (hit[K_55]) state_nx = ST_S2;
        ST_S2: begin
          if (hit[K_A0]) state_nx = ST_ARM_ON;
          if (hit[K_80]) state_nx = ST_S3;
        end
        ST_S3: if (hit[K_AA]) state_nx = ST_S4;
        ST_S4: if (hit[K_55]) state_nx = ST_S5;
        ST_S5: if (hit[K_20]) state_nx = ST_ARM_OFF;
        default: ;
      endcase
    end
    if (commit) state_nx = ST_IDLE;
  end

  always_comb begin
    allow_nx = 1'b0;
    if (wr_stb) begin
      if (armed) allow_nx = !pg_mismatch;
      else       allow_nx = !prot && (state_nx == ST_IDLE);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      wr_allow <= 1'b0;
      prot     <= 1'b0;
    end else begin
      state    <= state_nx;
      wr_allow <= allow_nx;
      if (commit) prot <= (state == ST_ARM_ON);
    end
  end
endmodule

// File: rtl/wp_seq_chk.sv
module wp_seq_chk
  import wp_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            wr_stb,
  input logic            cycle_done,
  input logic            wr_allow,
  input logic            prot,
  input logic            armed,
  input logic [NCMD-1:0] hit,
  input logic            pg_mismatch
);
  // R11
  allow_needs_stb_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_stb |=> !wr_allow);
  // R6
  prot_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !cycle_done |=> $stable(prot));
  // R3
  cmd_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && !armed && hit[K_AA]) |=> !wr_allow);
  // R7
  prot_block_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && !armed && prot && hit == '0) |=> !wr_allow);
  // R8
  page_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && armed && pg_mismatch) |=> !wr_allow);
endmodule

bind wp_seq wp_seq_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_stb      (wr_stb),
  .cycle_done  (cycle_done),
  .wr_allow    (wr_allow),
  .prot        (prot),
  .armed       (armed),
  .hit         (hit),
  .pg_mismatch (pg_mismatch)
);

// File: tb/wp_seq_tb.sv
module wp_seq_tb;
  localparam int CLK_PER = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_stb = 1'b0;
  logic [16:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        cycle_done = 1'b0;
  logic        wr_allow, prot;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";
  bit    done_flag = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  wp_seq u_dut (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .cycle_done(cycle_done),
    .wr_allow(wr_allow), .prot(prot)
  );

  // behavioural reference model: unprotect list, with the A0 branch at index 2
  int seq_a [6] = '{'h5555, 'h2AAA, 'h5555, 'h5555, 'h2AAA, 'h5555};
  int seq_d [6] = '{'hAA, 'h55, 'h80, 'hAA, 'h55, 'h20};
  int m_prog = 0, m_armed = 0, m_page = 0;
  bit m_pgset = 0, m_prot = 0, m_allow = 0;

  always @(posedge clk) begin
    int a15, nxt_armed, nxt_prog, nxt_page;
    bit nxt_allow, nxt_pgset;
    a15 = int'(wr_addr) & 'h7FFF;
    nxt_armed = m_armed; nxt_prog = m_prog; nxt_page = m_page;
    nxt_pgset = m_pgset; nxt_allow = 0;
    if (rst) begin
      m_prog <= 0; m_armed <= 0; m_pgset <= 0; m_prot <= 0; m_allow <= 0;
    end else begin
      if (wr_stb) begin
        if (m_armed != 0) begin
          if (!m_pgset) begin
            nxt_allow = 1; nxt_page = int'(wr_addr) >> 7; nxt_pgset = 1;
          end else nxt_allow = ((int'(wr_addr) >> 7) == m_page);
        end else if (a15 == seq_a[m_prog] && int'(wr_data) == seq_d[m_prog]) begin
          nxt_prog = m_prog + 1;
          if (nxt_prog == 6) begin nxt_armed = 2; nxt_prog = 0; nxt_pgset = 0; end
        end else if (m_prog == 2 && a15 == 'h5555 && wr_data == 8'hA0) begin
          nxt_armed = 1; nxt_prog = 0; nxt_pgset = 0;
        end else if (a15 == 'h5555 && wr_data == 8'hAA) begin
          nxt_prog = 1;
        end else begin
          nxt_prog = 0; nxt_allow = !m_prot;
        end
      end
      if (cycle_done && m_armed != 0) begin
        m_prot <= (m_armed == 1);
        nxt_armed = 0; nxt_prog = 0; nxt_pgset = 0;
      end
      m_prog <= nxt_prog; m_armed <= nxt_armed; m_page <= nxt_page;
      m_pgset <= nxt_pgset; m_allow <= nxt_allow;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // per-cycle comparison with the model
  always @(negedge clk) begin
    if (!rst && !done_flag) begin
      check(cur_req, "model wr_allow", int'(wr_allow), int'(m_allow));
      check(cur_req, "model prot", int'(prot), int'(m_prot));
    end
  end

  task automatic wr(input int addr, input int data, input int exp);
    wr_stb = 1'b1; wr_addr = 17'(addr); wr_data = 8'(data);
    @(negedge clk);
    wr_stb = 1'b0;
    check(cur_req, "wr_allow", int'(wr_allow), exp);
  endtask

  task automatic pulse_done();
    cycle_done = 1'b1;
    @(negedge clk);
    cycle_done = 1'b0;
  endtask

  task automatic seq_on(input int hi);
    wr(hi | 'h5555, 'hAA, 0); wr(hi | 'h2AAA, 'h55, 0); wr(hi | 'h5555, 'hA0, 0);
  endtask

  task automatic seq_off();
    wr('h5555, 'hAA, 0); wr('h2AAA, 'h55, 0); wr('h5555, 'h80, 0);
    wr('h5555, 'hAA, 0); wr('h2AAA, 'h55, 0); wr('h5555, 'h20, 0);
  endtask

  initial begin
    #(CLK_PER * 100000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    done_flag = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cur_req = "R1";
    check("R1", "prot after reset", int'(prot), 0);
    check("R1", "wr_allow after reset", int'(wr_allow), 0);
    @(negedge clk);

    cur_req = "R2";
    wr('h01234, 'h11, 1);
    wr('h1FFFF, 'h00, 1);
    cur_req = "R11";
    @(negedge clk);
    check("R11", "wr_allow idle", int'(wr_allow), 0);

    cur_req = "R6";
    pulse_done();
    check("R6", "prot after stray done", int'(prot), 0);

    // R3, R4, R8: enable with upper bits set, data window on one page
    cur_req = "R4";
    seq_on('h18000);
    cur_req = "R8";
    wr('h04A03, 'h12, 1);
    wr('h04A7F, 'h13, 1);
    wr('h04B00, 'h14, 0);
    check("R4", "prot before commit", int'(prot), 0);
    cur_req = "R4";
    pulse_done();
    check("R4", "prot after commit", int'(prot), 1);

    cur_req = "R7";
    wr('h00100, 'h33, 0);
    wr('h12345, 'h44, 0);
    cur_req = "R6";
    pulse_done();
    check("R6", "prot after stray done", int'(prot), 1);

    // R9: broken sequence, then restart on repeated first step
    cur_req = "R9";
    wr('h5555, 'hAA, 0);
    wr('h2AAA, 'h55, 0);
    wr('h5555, 'h77, 0);
    wr('h2AAA, 'h55, 0);
    wr('h5555, 'hAA, 0);
    wr('h5555, 'hAA, 0);
    wr('h2AAA, 'h55, 0);
    wr('h5555, 'hA0, 0);
    wr('h00200, 'h99, 1);
    pulse_done();
    check("R9", "prot after restart seq", int'(prot), 1);

    // R5: disable, window after it
    cur_req = "R5";
    seq_off();
    wr('h07000, 'h01, 1);
    pulse_done();
    check("R5", "prot after disable commit", int'(prot), 0);
    wr('h00300, 'h02, 1);

    // R10: commit with no data bytes
    cur_req = "R10";
    seq_on(0);
    pulse_done();
    check("R10", "prot with no data", int'(prot), 1);
    wr('h00400, 'h03, 0);
    cur_req = "R10";
    seq_off();
    pulse_done();
    check("R10", "prot cleared with no data", int'(prot), 0);

    cur_req = "R3";
    wr('h5555, 'hAA, 0);
    wr('h2AAA, 'h55, 0);
    wr('h5555, 'h80, 0);
    wr('h1234, 'h00, 1);

    repeat (2) @(negedge clk);
    done_flag = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule